// File: doc/BRIEF.md
# Q-channel multiframe controller

This block keeps track of the slow multiframe that rides on the auxiliary framing bit, the N bit and the M bit of a basic-rate line frame. It sits beside the frame engine and receives one strobe per line frame. It can run in either role. In the network-side role it is the timing master. It counts frames modulo twenty and tells the transmitter which frames must send an inverted auxiliary-framing/N pair. It also tells the transmitter which frame carries M set to one.

In the terminal-side role it works from two flags that the receiver reports for the frame just finished: whether that frame arrived with the auxiliary-framing/N pair inverted (a marker), and the M bit of that frame. It locks onto a stable marker rhythm and realigns its own frame count to the markers. In the frame after each marker it flags that the outgoing auxiliary framing bit must be replaced with one bit from a four-bit Q word. The Q word is captured once per twenty-frame cycle.

Multiframing weakens the line's framing-violation guarantee, so the whole block is gated by an enable. The role pin may only change while the enable is low. All inputs are control-rate: there is one strobe per frame and no data stream, so the block has no valid/ready interface and applies no back-pressure. It must accept a strobe on any cycle.

Top module: `qmf_ctrl`

## Requirements
- R1: While `mf_en` is low, every output is 0 on the next cycle and after it: `frame_idx`, `mf_lock`, `tx_fan_invert`, `tx_m_bit`, `q_slot` and `q_bit`. All tracking state is cleared, and frame strobes are ignored.
- R2: In the network role (`te_mode`=0) with the block enabled, `frame_idx` starts at 0. It steps by one per `frame_stb`, wrapping from 19 to 0, and holds between strobes.
- R3: In the network role, `tx_fan_invert` is 1 exactly when `frame_idx` mod 5 equals 0, and `tx_m_bit` is 1 exactly when `frame_idx` is 0. `mf_lock` is 1.
- R4: In the network role, `rx_marker`, `rx_m` and `q_word` have no effect on any output, and `q_slot` and `q_bit` stay 0.
- R5: In the terminal role, a strobe with `rx_marker`=1 raises `mf_lock` one cycle later, but only if an earlier marker was seen since enable and exactly four strobes without a marker lie between the two markers.
- R6: In the terminal role, `mf_lock` falls one cycle after either of two strobes. The first is a strobe with a marker whose spacing from the previous marker is not five frames. The second is the fifth strobe after a marker, when that strobe arrives without a marker.
- R7: In the terminal role, a strobe with `rx_marker`=1 and `rx_m`=1 sets `frame_idx` to 1. A strobe with `rx_marker`=1 and `rx_m`=0 sets it to 5*g+1, where g is `frame_idx`/5 (integer division), or 1 if that quotient is 0.
- R8: In the terminal role, a strobe without a marker steps `frame_idx` by one modulo 20, whether locked or not.
- R9: In the terminal role, `q_slot` is 1 exactly when `mf_lock` is 1 and `frame_idx` mod 5 equals 1. While `q_slot` is 1, `q_bit` is bit `frame_idx`/5 of the captured Q word (bit 0 = first Q bit, sent at index 1). Otherwise `q_bit` is 0.
- R10: The Q word is captured from `q_word` on the strobe that moves `frame_idx` to 1 in the terminal role. Changes of `q_word` at any other time do not alter `q_bit`.
- R11: In the terminal role, `tx_fan_invert` and `tx_m_bit` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_en | input | 1 | Multiframing enable; low clears the block |
| te_mode | input | 1 | 0 = network role, 1 = terminal role (change only while disabled) |
| frame_stb | input | 1 | One-cycle pulse per line frame boundary |
| rx_marker | input | 1 | With `frame_stb`: the finished frame had the Fa/N pair inverted |
| rx_m | input | 1 | With `frame_stb`: M bit of the finished frame |
| q_word | input | 4 | Q bits to send, bit 0 first |
| frame_idx | output | 5 | Current frame position, 0 to 19 |
| mf_lock | output | 1 | Multiframe lock |
| tx_fan_invert | output | 1 | Network role: the current frame sends an inverted Fa/N pair |
| tx_m_bit | output | 1 | Network role: M bit value for the current frame |
| q_slot | output | 1 | Terminal role: the current frame's Fa position carries a Q bit |
| q_bit | output | 1 | Q bit to send in the current slot |

## Verification
Several functions can act on one strobe edge in the terminal role. A marker with M set that confirms five-frame spacing raises lock, realigns `frame_idx` to 1 and captures the Q word, all in the same cycle. The bench makes `q_word` differ on every frame, so the first Q slot shows whether the captured word was the one present on that edge rather than a neighbour's. Lock loss and realignment also coincide: a misplaced marker drops lock and moves `frame_idx` together. A swept marker period from one to eight frames judges both against an arithmetic model.

// File: rtl/qmf_pkg.sv
package qmf_pkg;

  typedef enum logic {
    ROLE_NT = 1'b0,
    ROLE_TE = 1'b1
  } qmf_role_e;

  typedef struct packed {
    logic stb;
    logic marker;
    logic m_flag;
  } qmf_rx_evt_t;

endpackage

// File: rtl/qmf_frame_ctr.sv
module qmf_frame_ctr #(
  parameter int SUB_LEN = 5,
  parameter int Q_SLOTS = 4,
  localparam int MF_LEN = SUB_LEN * Q_SLOTS,
  localparam int IDX_W  = $clog2(MF_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  qmf_pkg::qmf_role_e  role,
  input  qmf_pkg::qmf_rx_evt_t evt,
  output logic [IDX_W-1:0]    idx,
  output logic                load_q
);
  import qmf_pkg::*;

  logic [IDX_W-1:0] grp, grp_sel, realigned, wrap, nxt;

  always_comb begin
    grp       = idx / IDX_W'(SUB_LEN);
    grp_sel   = (grp == '0) ? IDX_W'(1) : grp;
    realigned = grp_sel * IDX_W'(SUB_LEN) + IDX_W'(1);
    wrap      = (idx == IDX_W'(MF_LEN - 1)) ? '0 : idx + IDX_W'(1);
    if (role == ROLE_TE && evt.marker)
      nxt = evt.m_flag ? IDX_W'(1) : realigned;
    else
      nxt = wrap;
  end

  assign load_q = !clear && evt.stb && (role == ROLE_TE) && (nxt == IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx <= '0;
    else if (clear)     idx <= '0;
    else if (evt.stb)   idx <= nxt;
  end

  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IDX_W'(MF_LEN));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !evt.stb) |=> $stable(idx));
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx == '0));

endmodule

// File: rtl/qmf_marker_trk.sv
module qmf_marker_trk #(
  parameter int SUB_LEN = 5,
  localparam int GAP_W = $clog2(SUB_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic evt,
  input  logic marker,
  output logic lock
);

  logic             seen;
  logic [GAP_W-1:0] gap;
  logic             on_time;

  assign on_time = (gap == GAP_W'(SUB_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else if (clear) begin
      lock <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else if (evt) begin
      if (marker) begin
        lock <= seen && on_time;
        seen <= 1'b1;
        gap  <= '0;
      end else begin
        if (on_time) lock <= 1'b0;
        if (gap != GAP_W'(SUB_LEN)) gap <= gap + GAP_W'(1);
      end
    end
  end

  // R5: lock only rises on a strobe that carried a marker
  a_r5_rise_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(evt && marker));
  // R6: lock only falls on a strobe or on disable
  a_r6_fall_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(evt || clear));
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= GAP_W'(SUB_LEN));

endmodule

// File: rtl/qmf_q_slot.sv
module qmf_q_slot #(
  parameter int SUB_LEN = 5,
  parameter int Q_SLOTS = 4,
  localparam int MF_LEN = SUB_LEN * Q_SLOTS,
  localparam int IDX_W  = $clog2(MF_LEN),
  localparam int SLOT_W = (Q_SLOTS > 1) ? $clog2(Q_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               active,
  input  logic               load,
  input  logic [Q_SLOTS-1:0] q_word,
  input  logic [IDX_W-1:0]   idx,
  input  logic               lock,
  output logic               q_slot,
  output logic               q_bit
);

  logic [Q_SLOTS-1:0] q_hold;
  logic [IDX_W-1:0]   phase;
  logic [SLOT_W-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_hold <= '0;
    else if (clear)  q_hold <= '0;
    else if (load)   q_hold <= q_word;
  end

  always_comb begin
    phase  = idx % IDX_W'(SUB_LEN);
    sel    = SLOT_W'(idx / IDX_W'(SUB_LEN));
    q_slot = active && lock && (phase == IDX_W'(1));
    q_bit  = q_slot && q_hold[sel];
  end

  // R9: a Q slot is only ever flagged under lock
  a_r9_slot_locked: assert property (@(posedge clk) disable iff (!rst_n)
    q_slot |-> lock);
  // R10: the captured word moves only on a capture strobe or on disable
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> $stable(q_hold));

endmodule

// File: rtl/qmf_ctrl.sv
module qmf_ctrl #(
  parameter int SUB_LEN = 5,
  parameter int Q_SLOTS = 4,
  localparam int MF_LEN = SUB_LEN * Q_SLOTS,
  localparam int IDX_W  = $clog2(MF_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mf_en,
  input  logic               te_mode,
  input  logic               frame_stb,
  input  logic               rx_marker,
  input  logic               rx_m,
  input  logic [Q_SLOTS-1:0] q_word,
  output logic [IDX_W-1:0]   frame_idx,
  output logic               mf_lock,
  output logic               tx_fan_invert,
  output logic               tx_m_bit,
  output logic               q_slot,
  output logic               q_bit
);
  import qmf_pkg::*;

  qmf_role_e    role;
  qmf_rx_evt_t  evt;
  logic         clear, te_lock, load_q, te_active, nt_active;

  assign role      = te_mode ? ROLE_TE : ROLE_NT;
  assign clear     = !mf_en;
  assign te_active = mf_en && (role == ROLE_TE);
  assign nt_active = mf_en && (role == ROLE_NT);

  always_comb begin
    evt.stb    = frame_stb;
    evt.marker = rx_marker && frame_stb;
    evt.m_flag = rx_m;
  end

  qmf_frame_ctr #(.SUB_LEN(SUB_LEN), .Q_SLOTS(Q_SLOTS)) u_frame_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .role   (role),
    .evt    (evt),
    .idx    (frame_idx),
    .load_q (load_q)
  );

  qmf_marker_trk #(.SUB_LEN(SUB_LEN)) u_marker_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear || (role != ROLE_TE)),
    .evt    (te_active && frame_stb),
    .marker (rx_marker),
    .lock   (te_lock)
  );

  qmf_q_slot #(.SUB_LEN(SUB_LEN), .Q_SLOTS(Q_SLOTS)) u_q_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .active (te_active),
    .load   (load_q),
    .q_word (q_word),
    .idx    (frame_idx),
    .lock   (te_lock),
    .q_slot (q_slot),
    .q_bit  (q_bit)
  );

  assign tx_fan_invert = nt_active && ((frame_idx % IDX_W'(SUB_LEN)) == '0);
  assign tx_m_bit      = nt_active && (frame_idx == '0);
  assign mf_lock       = nt_active || (te_active && te_lock);

  // R3: the M-marked frame is always one of the inverted frames
  a_r3_m_in_invert: assert property (@(posedge clk) disable iff (!rst_n)
    tx_m_bit |-> tx_fan_invert);
  // R11: the two transmit roles never overlap
  a_r11_roles_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_slot && tx_fan_invert));

endmodule

// File: tb/test_qmf_ctrl.sv
module test_qmf_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mf_en = 1'b0, te_mode = 1'b0, frame_stb = 1'b0;
  logic       rx_marker = 1'b0, rx_m = 1'b0;
  logic [3:0] q_word = 4'h0;
  logic [4:0] frame_idx;
  logic       mf_lock, tx_fan_invert, tx_m_bit, q_slot, q_bit;

  always #5 clk = ~clk;

  qmf_ctrl i_qmf_ctrl (
    .clk(clk), .rst_n(rst_n), .mf_en(mf_en), .te_mode(te_mode),
    .frame_stb(frame_stb), .rx_marker(rx_marker), .rx_m(rx_m), .q_word(q_word),
    .frame_idx(frame_idx), .mf_lock(mf_lock), .tx_fan_invert(tx_fan_invert),
    .tx_m_bit(tx_m_bit), .q_slot(q_slot), .q_bit(q_bit)
  );

  int checks = 0, errors = 0;
  int m_idx = 0, m_gap = 0;
  bit m_seen = 0, m_lock = 0, m_en = 0, m_te = 0;
  logic [3:0] m_q = 4'h0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    int e_inv, e_m, e_lock, e_slot, e_bit;
    e_inv  = (m_en && !m_te && (m_idx % 5 == 0)) ? 1 : 0;
    e_m    = (m_en && !m_te && m_idx == 0) ? 1 : 0;
    e_lock = (m_en && (!m_te || m_lock)) ? 1 : 0;
    e_slot = (m_en && m_te && m_lock && (m_idx % 5 == 1)) ? 1 : 0;
    e_bit  = e_slot ? int'(m_q[m_idx / 5]) : 0;
    chk(tag, "frame_idx", int'(frame_idx), m_en ? m_idx : 0);
    chk(tag, "tx_fan_invert", int'(tx_fan_invert), e_inv);
    chk(tag, "tx_m_bit", int'(tx_m_bit), e_m);
    chk(tag, "mf_lock", int'(mf_lock), e_lock);
    chk(tag, "q_slot", int'(q_slot), e_slot);
    chk(tag, "q_bit", int'(q_bit), e_bit);
  endtask

  task automatic model_clear();
    m_idx = 0; m_gap = 0; m_seen = 0; m_lock = 0; m_q = 4'h0;
  endtask

  task automatic model_step(bit mk, bit mm, logic [3:0] qw);
    int n, g;
    if (!m_en) begin model_clear(); return; end
    if (!m_te) begin m_idx = (m_idx + 1) % 20; return; end
    if (mk) begin
      if (mm) n = 1;
      else begin g = m_idx / 5; if (g == 0) g = 1; n = 5 * g + 1; end
    end else n = (m_idx + 1) % 20;
    if (n == 1) m_q = qw;
    if (mk) begin
      m_lock = m_seen && (m_gap == 4);
      m_seen = 1; m_gap = 0;
    end else begin
      if (m_gap == 4) m_lock = 0;
      if (m_gap < 5) m_gap++;
    end
    m_idx = n;
  endtask

  task automatic frame(bit mk, bit mm, logic [3:0] qw, string tag);
    @(negedge clk);
    frame_stb = 1'b1; rx_marker = mk; rx_m = mm; q_word = qw;
    model_step(mk, mm, qw);
    @(negedge clk);
    frame_stb = 1'b0; rx_marker = 1'b0; rx_m = 1'b0;
    check_outs(tag);
    q_word = ~qw;              // R10: idle change of the Q word is ignored
    @(negedge clk);
    check_outs("R10");
  endtask

  task automatic set_mode(bit en, bit te, string tag);
    @(negedge clk);
    mf_en = en; te_mode = te;
    m_en = en; m_te = te;
    if (!en) model_clear();
    @(negedge clk);
    check_outs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outs("R1");          // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");

    // R2/R3 with noisy receive inputs (R4)
    set_mode(1, 0, "R3");
    for (int k = 0; k < 45; k++)
      frame(k % 3 == 0, k % 2 == 1, 4'(k * 7), (k % 2 == 0) ? "R2" : "R4");

    // R1: disabled, strobes ignored
    set_mode(0, 0, "R1");
    for (int k = 0; k < 6; k++) frame(1, 1, 4'(k), "R1");

    // R5/R9/R10: regular terminal-side marker rhythm, changing Q word
    set_mode(1, 1, "R11");
    for (int k = 0; k < 70; k++)
      frame(k % 5 == 0, k % 20 == 0, 4'(k * 3 + 5), "R5");

    // R6/R7: marker period sweep
    for (int p = 1; p <= 8; p++) begin
      set_mode(0, 0, "R1");
      set_mode(1, 1, "R11");
      for (int k = 0; k < 26; k++)
        frame(k % p == 0, k % (4 * p) == 0, 4'(k + p), (p == 5) ? "R9" : "R6");
    end

    // R6: missing marker, then misplaced marker; R7 realign without M; R8 free-run
    set_mode(0, 0, "R1");
    set_mode(1, 1, "R11");
    for (int k = 0; k < 7; k++) frame(1'b0, 1'b0, 4'h9, "R8");
    for (int k = 0; k < 11; k++) frame(k % 5 == 0, 1'b0, 4'hA, "R7");
    for (int k = 0; k < 6; k++) frame(1'b0, 1'b0, 4'h3, "R6");
    for (int k = 0; k < 11; k++) frame(k % 5 == 0, k == 0, 4'h6, "R9");
    frame(1'b1, 1'b0, 4'h1, "R6");
    for (int k = 0; k < 8; k++) frame(1'b0, 1'b0, 4'h2, "R8");

    set_mode(0, 1, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule